// File: doc/BRIEF.md
# Per-Port Edge Event and Interrupt Unit

This block is the interrupt section of one general-purpose I/O port with eight pins. It watches pin levels that have already been synchronized to its clock. Each pin detects one edge polarity, either rising or falling, and a per-pin polarity bit picks which. When the chosen edge is seen on an enabled pin, a sticky event bit is set. The port drives one interrupt line, which is high while any enabled pin has a pending event.

Software works the block through a simple register bus with a write strobe and a combinational read port. Pending events are acknowledged by writing ones to the event register. A force register lets a test inject events. Software can emulate detection on both edges by flipping a pin's polarity bit after each event. Flipping the polarity never creates an event by itself, because detection only compares two successive pin samples.

Top module: `edge_event_port`

## Requirements
- R1: After reset the event, enable, force and polarity registers all read 0 and `irq` is 0.
- R2: With its polarity bit at 1 and its enable bit at 1, a pin that goes from 0 to 1 sets its event bit in the cycle after the new level is sampled.
- R3: With its polarity bit at 0 and its enable bit at 1, a pin that goes from 1 to 0 sets its event bit in the cycle after the new level is sampled.
- R4: An edge of the polarity that was not selected leaves the event register unchanged.
- R5: An edge on a pin whose enable bit is 0 sets no event.
- R6: A write to the event register at offset 0x14 clears each event bit whose data bit is 1. Bits written as 0 are left alone, and data bits above bit 7 are ignored.
- R7: If a selected edge is detected in the same cycle as an acknowledge of that pin's event bit, the bit stays set.
- R8: A force bit at 1 (offset 0x1C) sets the matching event bit on every cycle it is held, whether or not that pin is enabled. Writing 0 to the force register stops the injection.
- R9: `irq` is 1 exactly when some pin has both its event bit and its enable bit (offset 0x18) at 1. Clearing the enable bit drops `irq` but keeps the event pending.
- R10: Changing a polarity bit (offset 0x20) while the pin level is steady creates no event.
- R11: The event, enable, force and polarity registers read back at offsets 0x14, 0x18, 0x1C and 0x20 in bits 7:0. The upper read bits are 0, and every other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 32 | Read data (combinational) |
| pin_in | input | 8 | Synchronized pin levels |
| irq | output | 1 | Port interrupt request |

## Verification
Two functions can land on the same clock edge. The first is an acknowledge and a fresh detection on the same pin. The bench provokes it by changing the pin and writing the acknowledge in the same cycle, then judges it by the event bit still reading 1. The second is an acknowledge and a held force bit. The bench writes the acknowledge while the force bit is held and expects the bit to stay set; after the force is removed, a second acknowledge must clear it.

// File: rtl/edge_event_port.sv
module edge_event_port #(
  parameter int PINS    = 8,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] OFS_EVT = 8'h14,
  parameter logic [ADDR_W-1:0] OFS_EN  = 8'h18,
  parameter logic [ADDR_W-1:0] OFS_FRC = 8'h1C,
  parameter logic [ADDR_W-1:0] OFS_POL = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [PINS-1:0]   pin_in,
  output logic              irq
);
  localparam int PAD_W = DATA_W - PINS;

  logic [PINS-1:0] evt_q, en_q, frc_q, pol_q, prev_q;
  logic [PINS-1:0] wdat, rise, fall, seen, ack;

  assign wdat = wr_data[PINS-1:0];
  assign rise = pin_in & ~prev_q;
  assign fall = ~pin_in & prev_q;
  assign seen = ((pol_q & rise) | (~pol_q & fall)) & en_q;
  assign ack  = (wr_en && wr_addr == OFS_EVT) ? wdat : '0;
  assign irq  = |(evt_q & en_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_q  <= '0;
      en_q   <= '0;
      frc_q  <= '0;
      pol_q  <= '0;
      prev_q <= '0;
    end else begin
      prev_q <= pin_in;
      evt_q  <= (evt_q & ~ack) | seen | frc_q;
      if (wr_en && wr_addr == OFS_EN)  en_q  <= wdat;
      if (wr_en && wr_addr == OFS_FRC) frc_q <= wdat;
      if (wr_en && wr_addr == OFS_POL) pol_q <= wdat;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      OFS_EVT: rd_data = {{PAD_W{1'b0}}, evt_q};
      OFS_EN:  rd_data = {{PAD_W{1'b0}}, en_q};
      OFS_FRC: rd_data = {{PAD_W{1'b0}}, frc_q};
      OFS_POL: rd_data = {{PAD_W{1'b0}}, pol_q};
      default: rd_data = '0;
    endcase
  end
endmodule

module edge_event_port_chk #(
  parameter int PINS   = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFS_EVT = 8'h14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [PINS-1:0]   wr_low,
  input logic [PINS-1:0]   pin_in,
  input logic              irq,
  input logic [PINS-1:0]   evt_q,
  input logic [PINS-1:0]   en_q,
  input logic [PINS-1:0]   frc_q
);
  logic [PINS-1:0] ack_seen;
  assign ack_seen = (wr_en && wr_addr == OFS_EVT) ? wr_low : '0;

  // R6
  pending_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(evt_q) & ~$past(ack_seen)) & ~evt_q) == '0));

  // R8
  force_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frc_q != '0) |=> ((evt_q & $past(frc_q)) == $past(frc_q)));

  // R5
  new_event_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((evt_q & ~$past(evt_q)) & ~$past(en_q) & ~$past(frc_q)) == '0));

  // R9
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);

  // R10
  steady_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_in == $past(pin_in) && frc_q == '0) |=> ((evt_q & ~$past(evt_q)) == '0));
endmodule

bind edge_event_port edge_event_port_chk #(
  .PINS(PINS), .ADDR_W(ADDR_W), .OFS_EVT(OFS_EVT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_low(wr_data[PINS-1:0]), .pin_in(pin_in), .irq(irq),
  .evt_q(evt_q), .en_q(en_q), .frc_q(frc_q)
);

// File: tb/edge_event_port_tb.sv
module edge_event_port_tb;
  localparam logic [7:0] EVT = 8'h14, EN = 8'h18, FRC = 8'h1C, POL = 8'h20;

  logic        clk = 0, rst_n = 0, wr_en = 0, irq;
  logic [7:0]  wr_addr = 0, rd_addr = 0, pin_in = 0;
  logic [31:0] wr_data = 0, rd_data;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  edge_event_port u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .pin_in(pin_in), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rdchk(input string req, input logic [7:0] a, input logic [31:0] exp);
    rd_addr = a; #1; chk(req, rd_data, exp);
  endtask

  task automatic pin(input int b, input logic v);
    @(negedge clk); pin_in[b] = v; @(negedge clk);
  endtask

  task automatic t_reset;
    rdchk("R1 evt", EVT, 0); rdchk("R1 en", EN, 0);
    rdchk("R1 frc", FRC, 0); rdchk("R1 pol", POL, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_rise;
    wr(POL, 1); wr(EN, 1);
    pin(0, 1); rdchk("R2 rise", EVT, 1); chk("R9 irq on", irq, 1);
    wr(EVT, 1); pin(0, 0); rdchk("R4 fall ignored", EVT, 0);
  endtask

  task automatic t_fall;
    wr(EN, 3);
    pin(1, 1); rdchk("R4 rise ignored", EVT, 0);
    pin(1, 0); rdchk("R3 fall", EVT, 2);
    wr(EVT, 2);
  endtask

  task automatic t_disabled;
    wr(POL, 5);
    pin(2, 1); rdchk("R5 disabled", EVT, 0); chk("R5 irq", irq, 0);
  endtask

  task automatic t_w1c;
    pin(0, 1); pin(1, 1); pin(1, 0);
    rdchk("R6 setup", EVT, 3);
    wr(EVT, 32'hFFFF_FF00); rdchk("R6 upper bits", EVT, 3);
    wr(EVT, 2); rdchk("R6 one bit", EVT, 1);
    wr(EVT, 1); rdchk("R6 clear", EVT, 0);
  endtask

  task automatic t_collide;
    pin(0, 0); pin(0, 1); rdchk("R7 setup", EVT, 1);
    pin(0, 0);
    @(negedge clk); pin_in[0] = 1; wr_en = 1; wr_addr = EVT; wr_data = 1;
    @(negedge clk); wr_en = 0;
    rdchk("R7 edge with ack", EVT, 1);
    wr(EVT, 1); rdchk("R7 later ack", EVT, 0);
  endtask

  task automatic t_pol_change;
    wr(POL, 4); @(negedge clk);
    rdchk("R10 pol to fall", EVT, 0);
    wr(POL, 5); @(negedge clk);
    rdchk("R10 pol to rise", EVT, 0);
  endtask

  task automatic t_force;
    wr(FRC, 8'h10); @(negedge clk);
    rdchk("R8 forced", EVT, 8'h10); chk("R9 masked", irq, 0);
    wr(EVT, 8'h10); rdchk("R8 held", EVT, 8'h10);
    wr(FRC, 0); wr(EVT, 8'h10); @(negedge clk);
    rdchk("R8 off", EVT, 0);
  endtask

  task automatic t_irq;
    wr(FRC, 8'h10); wr(FRC, 0);
    chk("R9 no enable", irq, 0);
    wr(EN, 8'h13); chk("R9 enabled", irq, 1);
    wr(EN, 8'h03); chk("R9 mask drop", irq, 0);
    rdchk("R9 kept", EVT, 8'h10);
    wr(EVT, 8'h10);
  endtask

  task automatic t_regs;
    wr(EN, 32'h0000_ABC5); rdchk("R11 en", EN, 8'hC5);
    rdchk("R11 pol", POL, 5); rdchk("R11 frc", FRC, 0);
    rdchk("R11 hole", 8'h24, 0); rdchk("R11 base", 8'h00, 0);
    wr(EN, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset; t_rise; t_fall; t_disabled; t_w1c;
    t_collide; t_pol_change; t_force; t_irq; t_regs;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule